// File: doc/BRIEF.md
# DRAM Refresh and Start-Up Sequencer

This block owns the refresh side of an asynchronous DRAM. It holds off all traffic after reset, then brings the memory up, then keeps every row alive. The hold-off is a quiet start-up pause. Bring-up is a burst of CAS-before-RAS refresh cycles, which use the memory's internal row counter, so the block never drives a row address.

After bring-up it raises a periodic refresh demand, sized so that the whole array is refreshed inside the retention period. The demand goes to the access controller through a request/grant pair. While a refresh runs, the block drives the three strobes and signals that it holds the bus.

Demands that pile up while the controller keeps the bus are counted, up to a fixed limit. They are then served back to back. A ready flag tells the controller when normal accesses may begin. All timings are clock-count parameters.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `ras_n`, `cas_n` and `we_n` are 1, and `ready`, `req` and `bus_hold` are 0.
- R2: For the first PAUSE_CYC clock edges after reset is released, `req` stays 0 and `ras_n` and `cas_n` stay 1. `req` goes to 1 right after edge PAUSE_CYC.
- R3: After the pause, exactly INIT_CYC refresh cycles are issued. Each one waits for `grant`. `ready` goes to 1 on the edge that ends the precharge of the last of them, and not before.
- R4: A refresh cycle drives `cas_n` low for CSR_CYC cycles with `ras_n` still high. Both then stay low for RAS_CYC cycles, and both return high on the same edge.
- R5: `we_n` is 1 at all times, so that no refresh cycle is taken as a test-mode entry.
- R6: After `ras_n` rises, the cycle keeps `bus_hold` at 1 with both strobes high for max(RP_CYC, RPC_CYC) cycles. `ras_n` is always high for at least RP_CYC cycles before `cas_n` falls.
- R7: `req` is 1 only when the block is idle and has work. A refresh begins (`cas_n` low) on the cycle after `req` and `grant` are both sampled 1. `req` is 0 and `bus_hold` is 1 from then until the cycle ends.
- R8: Once `ready` is 1, a refresh demand arises every REFI_CYC cycles. With `grant` held at 1, successive `ras_n` falls are exactly REFI_CYC cycles apart. The first falls CSR_CYC+1 cycles after the first demand.
- R9: Demands that arrive while `grant` is 0 are counted up to PEND_MAX. When the bus is granted, exactly min(demands, PEND_MAX) refreshes are issued back to back.
- R10: Once `ready` is 1 it stays 1 until the next reset.
- R11: With the bus granted, at least ROWS refreshes are issued in every window of ROWS*REFI_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Controller grants the DRAM bus to the refresh side |
| req | output | 1 | Refresh side asks for the bus |
| bus_hold | output | 1 | Refresh cycle in progress, strobes owned by this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, kept high |
| ready | output | 1 | Bring-up done, normal accesses allowed |

## Verification
A phase register stuck in the wrong state shows at the ports within one clock. It appears as an early `req` or strobe during the pause, or as a `ready` flag that is early or late against the known end of the eighth precharge.

A cycle engine with a wrong length moves the `ras_n` fall or the `bus_hold` release by whole cycles. Per-cycle tracing of the bring-up burst catches such a shift on the first refresh.

Faults in the demand counter stay hidden until the bus is withheld. At that point they appear as a wrong count of back-to-back refreshes once `grant` returns. A timer off by one shows as a wrong spacing between `ras_n` falls in steady state.

// File: rtl/drs_pkg.sv
package drs_pkg;

    // Bring-up phase of the sequencer.
    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_INIT  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    // State of one CAS-before-RAS refresh cycle.
    typedef enum logic [1:0] {
        CY_IDLE  = 2'd0,
        CY_SETUP = 2'd1,
        CY_ACT   = 2'd2,
        CY_PRE   = 2'd3
    } cyc_e;

    // Strobe bundle, all active low.
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    // Strobe levels for each cycle state: CAS leads RAS, WE stays high.
    function automatic strobe_t strobe_of(input cyc_e s);
        strobe_t r;
        r.we_n  = 1'b1;
        r.ras_n = (s != CY_ACT);
        r.cas_n = !((s == CY_SETUP) || (s == CY_ACT));
        return r;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold the values 0 .. n-1.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/drs_interval.sv
module drs_interval
    import drs_pkg::*;
#(
    parameter int REFI_CYC = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int TW = cnt_width(REFI_CYC);
    localparam logic [TW-1:0] T_LAST = TW'(REFI_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == T_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + TW'(1);
        end
    end

    assign tick = en && (cnt == T_LAST);
endmodule

// File: rtl/drs_pending.sv
module drs_pending
    import drs_pkg::*;
#(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic nz
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] P_TOP = PW'(PEND_MAX);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != P_TOP) cnt <= cnt + PW'(1);
                2'b01:   if (cnt != '0)    cnt <= cnt - PW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign nz = (cnt != '0);
endmodule

// File: rtl/drs_cbr_engine.sv
module drs_cbr_engine
    import drs_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int RAS_CYC = 9,
    parameter int RP_CYC  = 7,
    parameter int RPC_CYC = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output strobe_t strobe,
    output logic    idle,
    output logic    done
);
    localparam int PRE_CYC = max_of(RP_CYC, RPC_CYC);
    localparam int LONGEST = max_of(max_of(CSR_CYC, RAS_CYC), PRE_CYC);
    localparam int CW      = cnt_width(LONGEST);
    localparam logic [CW-1:0] SETUP_LAST = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] ACT_LAST   = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_CYC - 1);

    cyc_e          state;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CY_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                CY_IDLE: begin
                    if (start) begin
                        state <= CY_SETUP;
                        cnt   <= SETUP_LAST;
                    end
                end
                CY_SETUP: begin
                    if (last) begin
                        state <= CY_ACT;
                        cnt   <= ACT_LAST;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                CY_ACT: begin
                    if (last) begin
                        state <= CY_PRE;
                        cnt   <= PRE_LAST;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                CY_PRE: begin
                    if (last) begin
                        state <= CY_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= CY_IDLE;
            endcase
        end
    end

    assign strobe = strobe_of(state);
    assign idle   = (state == CY_IDLE);
    assign done   = (state == CY_PRE) && last;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import drs_pkg::*;
#(
    parameter int PAUSE_CYC = 25000,
    parameter int INIT_CYC  = 8,
    parameter int REFI_CYC  = 1950,
    parameter int CSR_CYC   = 1,
    parameter int RAS_CYC   = 9,
    parameter int RP_CYC    = 7,
    parameter int RPC_CYC   = 1,
    parameter int PEND_MAX  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic grant,
    output logic req,
    output logic bus_hold,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready
);
    localparam int PW = cnt_width(PAUSE_CYC);
    localparam int IW = $clog2(INIT_CYC + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [IW-1:0] INIT_LOAD  = IW'(INIT_CYC);

    phase_e        phase;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_left;
    logic          run;
    logic          tick;
    logic          pend_nz;
    logic          eng_idle;
    logic          eng_done;
    logic          start;
    strobe_t       strobe;

    // Bring-up sequencing: quiet pause, then a fixed burst of refreshes.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PAUSE;
            pause_cnt <= '0;
            init_left <= INIT_LOAD;
        end else begin
            unique case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == PAUSE_LAST) phase <= PH_INIT;
                    else                         pause_cnt <= pause_cnt + PW'(1);
                end
                PH_INIT: begin
                    if (eng_done) begin
                        init_left <= init_left - IW'(1);
                        if (init_left == IW'(1)) phase <= PH_RUN;
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    assign run   = (phase == PH_RUN);
    assign req   = eng_idle && ((phase == PH_INIT) || (run && pend_nz));
    assign start = req && grant;

    drs_interval #(
        .REFI_CYC(REFI_CYC)
    ) i_interval (
        .clk (clk),
        .rst (rst),
        .en  (run),
        .tick(tick)
    );

    drs_pending #(
        .PEND_MAX(PEND_MAX)
    ) i_pending (
        .clk(clk),
        .rst(rst),
        .inc(tick),
        .dec(start && run),
        .nz (pend_nz)
    );

    drs_cbr_engine #(
        .CSR_CYC(CSR_CYC),
        .RAS_CYC(RAS_CYC),
        .RP_CYC (RP_CYC),
        .RPC_CYC(RPC_CYC)
    ) i_engine (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .strobe(strobe),
        .idle  (eng_idle),
        .done  (eng_done)
    );

    assign ras_n    = strobe.ras_n;
    assign cas_n    = strobe.cas_n;
    assign we_n     = strobe.we_n;
    assign bus_hold = !eng_idle;
    assign ready    = run;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int PAUSE_CYC = 25000,
    parameter int INIT_CYC  = 8,
    parameter int RP_CYC    = 7
) (
    input logic clk,
    input logic rst,
    input logic grant,
    input logic req,
    input logic bus_hold,
    input logic ras_n,
    input logic cas_n,
    input logic ready
);
    localparam int SW = $clog2(PAUSE_CYC + 1);
    localparam int HW = $clog2(RP_CYC + 1);
    localparam int FW = $clog2(INIT_CYC + 2);

    logic [SW-1:0] since;
    logic [HW-1:0] ras_hi;
    logic [FW-1:0] falls;
    logic          ras_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since  <= '0;
            ras_hi <= HW'(RP_CYC);
            falls  <= '0;
            ras_q  <= 1'b1;
        end else begin
            if (since != SW'(PAUSE_CYC)) since <= since + SW'(1);
            if (!ras_n)                       ras_hi <= '0;
            else if (ras_hi != HW'(RP_CYC))   ras_hi <= ras_hi + HW'(1);
            if (ras_q && !ras_n && !ready && falls != FW'(INIT_CYC + 1))
                falls <= falls + FW'(1);
            ras_q <= ras_n;
        end
    end

    p_quiet_pause_r2: assert property (@(posedge clk) disable iff (rst)
        (since < SW'(PAUSE_CYC)) |-> (ras_n && cas_n && !req));

    p_init_count_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (falls == FW'(INIT_CYC)));

    p_cas_first_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    p_rise_together_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |-> $rose(ras_n));

    p_precharge_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (ras_hi >= HW'(RP_CYC)));

    p_hold_strobes_r7: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> bus_hold);

    p_req_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (req && grant) |=> (!req && bus_hold));

    p_grant_first_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> $past(req && grant));

    p_ready_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
endmodule

bind dram_refresh_seq drs_checker #(
    .PAUSE_CYC(PAUSE_CYC),
    .INIT_CYC (INIT_CYC),
    .RP_CYC   (RP_CYC)
) i_drs_checker (
    .clk     (clk),
    .rst     (rst),
    .grant   (grant),
    .req     (req),
    .bus_hold(bus_hold),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .ready   (ready)
);

// File: tb/test_dram_refresh_seq.sv
`timescale 1ns/1ps
module test_dram_refresh_seq;
    localparam int PAUSE = 40;
    localparam int INIT  = 8;
    localparam int REFI  = 100;
    localparam int CSR   = 2;
    localparam int RAS   = 4;
    localparam int RP    = 3;
    localparam int RPC   = 2;
    localparam int PEND  = 8;
    localparam int ROWS  = 16;
    localparam int CYC   = CSR + RAS + RP + 1;   // one refresh plus the idle request cycle

    // {intervals the bus is withheld after the first demand, expected burst}
    localparam int VEC [7][2] = '{'{0, 1}, '{1, 2}, '{3, 4}, '{6, 7},
                                  '{7, 8}, '{10, 8}, '{12, 8}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic grant = 1'b0;
    logic req, bus_hold, ras_n, cas_n, we_n, ready;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    int we_low = 0;
    int rdy_drop = 0;
    bit seen_rdy = 1'b0;

    always #4 clk = ~clk;

    dram_refresh_seq #(
        .PAUSE_CYC(PAUSE), .INIT_CYC(INIT), .REFI_CYC(REFI), .CSR_CYC(CSR),
        .RAS_CYC(RAS), .RP_CYC(RP), .RPC_CYC(RPC), .PEND_MAX(PEND)
    ) i_dram_refresh_seq (
        .clk(clk), .rst(rst), .grant(grant), .req(req), .bus_hold(bus_hold),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitors for R5 and R10 over the whole run.
    always @(negedge clk) begin
        if (!rst) begin
            if (we_n !== 1'b1) we_low++;
            if (seen_rdy && ready !== 1'b1) rdy_drop++;
            if (ready === 1'b1) seen_rdy = 1'b1;
        end
    end

    initial begin
        int errs, err4, err6, err7, err3, falls, f1, f2;
        bit pr;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, "R1 strobes",
            {ras_n, cas_n, we_n}, 7);
        chk(ready === 1'b0 && req === 1'b0 && bus_hold === 1'b0, "R1 flags",
            {ready, req, bus_hold}, 0);
        rst = 1'b0;
        // R2: quiet pause
        errs = 0;
        for (int k = 1; k < PAUSE; k++) begin
            @(negedge clk);
            if (req !== 1'b0 || ras_n !== 1'b1 || cas_n !== 1'b1) errs++;
        end
        chk(errs == 0, "R2 quiet during pause", errs, 0);
        @(negedge clk);
        chk(req === 1'b1, "R2 req after pause", req, 1);
        grant = 1'b1;
        // R3/R4/R6/R7: trace of the bring-up burst
        err3 = 0; err4 = 0; err6 = 0; err7 = 0; falls = 0; pr = 1'b1;
        for (int k = PAUSE + 1; k <= PAUSE + INIT * CYC; k++) begin
            int ph;
            bit e_cas, e_ras, e_hold, e_req, e_rdy;
            @(negedge clk);
            ph     = (k - PAUSE - 1) % CYC;
            e_cas  = !(ph < CSR + RAS);
            e_ras  = !(ph >= CSR && ph < CSR + RAS);
            e_hold = (ph < CYC - 1);
            e_req  = (ph == CYC - 1) && (k < PAUSE + INIT * CYC);
            e_rdy  = (k >= PAUSE + INIT * CYC);
            if (ras_n !== e_ras || cas_n !== e_cas) err4++;
            if (bus_hold !== e_hold) err6++;
            if (req !== e_req) err7++;
            if (ready !== e_rdy) err3++;
            if (pr && !ras_n) falls++;
            pr = ras_n;
        end
        chk(err4 == 0, "R4 CAS-before-RAS strobe pattern", err4, 0);
        chk(err6 == 0, "R6 precharge with bus held", err6, 0);
        chk(err7 == 0, "R7 req only when idle with work", err7, 0);
        chk(err3 == 0, "R3 ready timing", err3, 0);
        chk(falls == INIT, "R3 bring-up refresh count", falls, INIT);
        // R8: steady interval, grant held
        f1 = -1; f2 = -1;
        for (int c = 1; c <= 2 * REFI + 10; c++) begin
            @(negedge clk);
            if (pr && !ras_n) begin
                if (f1 < 0) f1 = c; else if (f2 < 0) f2 = c;
            end
            pr = ras_n;
        end
        chk(f1 == REFI + 1 + CSR, "R8 first refresh after ready", f1, REFI + 1 + CSR);
        chk(f2 - f1 == REFI, "R8 refresh spacing", f2 - f1, REFI);
        // R11: budget over one retention window
        falls = 0;
        for (int c = 0; c < ROWS * REFI; c++) begin
            @(negedge clk);
            if (pr && !ras_n) falls++;
            pr = ras_n;
        end
        chk(falls >= ROWS, "R11 refreshes per window", falls, ROWS);
        // R9: withheld bus, vector walk
        for (int v = 0; v < 7; v++) begin
            int w;
            grant = 1'b0;
            w = 0;
            do begin
                @(negedge clk);
                w++;
            end while (req !== 1'b1 && w < 4 * REFI);
            repeat (VEC[v][0] * REFI) @(negedge clk);
            grant = 1'b1;
            falls = 0;
            pr = ras_n;
            for (int c = 0; c < PEND * CYC + 10; c++) begin
                @(negedge clk);
                if (pr && !ras_n) falls++;
                pr = ras_n;
            end
            chk(falls == VEC[v][1], "R9 burst after withheld grant", falls, VEC[v][1]);
        end
        chk(we_low == 0, "R5 we_n held high", we_low, 0);
        chk(rdy_drop == 0, "R10 ready never drops", rdy_drop, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule